// File: doc/BRIEF.md
# Receive FIFO with Trigger Flag

This block buffers audio samples handed over by a serial receiver's deserializer in an eight-entry first-in first-out store. Software or a DMA engine drains it through a register-style data port. A two-bit trigger code selects how many stored samples count as "enough". A sticky full flag rises when the fill reaches that level and drives a request line that starts interrupt service or DMA transfers.

The flag is kept by a two-state machine. FLAG_CLEAR moves to FLAG_RAISED on the RAISE transition, taken at the clock edge where the fill count becomes equal to or greater than the selected level. FLAG_RAISED returns to FLAG_CLEAR on one of two transitions. SW_CLEAR is taken when software writes 0 to the flag bit of the status register. DMA_DRAIN is taken when a DMA read pops an entry. Both are taken only if the fill count after that edge is below the level. Writing 1 to the flag bit does nothing. A flush bit in the control register empties the store and holds it empty. An overflow bit records any sample lost because the store was full.

Top module: `rx_trig_fifo`

## Requirements
- R1: After reset, fill_cnt is 0, full_flag, ovf_flag, rxi_req and flush_q are 0, trig_code_q is 2'b00, and rd_data is the empty value (all zeros by default).
- R2: Accepted samples are read out in the order they were written. rd_data shows the oldest entry while rd_strobe pops it at the clock edge. fill_cnt gives the number of stored entries (0 to 8).
- R3: Trigger code 2'b00, 2'b01, 2'b10 and 2'b11 select levels of 1, 2, 4 and 6 entries. full_flag rises at the same edge at which fill_cnt reaches or passes the level, and rxi_req follows full_flag.
- R4: A status write with sts_full_wr=0 clears full_flag only if fill_cnt after that edge is below the level. A write with sts_full_wr=1 leaves it unchanged. The flag stays 1 after CPU reads take the count below the level, until such a write.
- R5: A read with rd_by_dma=1 that leaves fill_cnt below the level clears full_flag at that edge, with no status write.
- R6: A control write with ctl_flush=1 empties the store. From the second edge after the write, fill_cnt reads 0 and incoming samples are discarded while the bit stays 1. A 0 write to the flag bit then clears full_flag. After the bit is written back to 0, new samples are stored and read normally.
- R7: A read while the store is empty returns the empty value and moves no pointer. A sample pushed afterwards is the next one read.
- R8: A push while fill_cnt is 8 and no read is popping is dropped and sets ovf_flag. ovf_flag holds until a status write with sts_ovf_wr=0. A write with sts_ovf_wr=1 leaves it set.
- R9: A push and a read in the same cycle on a non-empty store, including a full one, leave fill_cnt unchanged, and the pushed sample joins the tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| des_valid | input | 1 | Deserializer presents a sample this cycle |
| des_data | input | DW | Sample from the deserializer |
| rd_strobe | input | 1 | Read of the data register; pops one entry |
| rd_by_dma | input | 1 | Marks the read as issued by the DMA engine |
| rd_data | output | DW | Oldest stored sample, or the empty value |
| ctl_we | input | 1 | Control register write |
| ctl_trig_code | input | 2 | Trigger code to write |
| ctl_flush | input | 1 | Flush bit to write |
| sts_we | input | 1 | Status register write |
| sts_full_wr | input | 1 | Value written to the flag bit (0 requests clear) |
| sts_ovf_wr | input | 1 | Value written to the overflow bit (0 clears) |
| trig_code_q | output | 2 | Stored trigger code |
| flush_q | output | 1 | Stored flush bit |
| full_flag | output | 1 | Sticky receive-full flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| fill_cnt | output | CW | Number of stored entries |
| rxi_req | output | 1 | Receive-full request to interrupt or DMA logic |

## Verification
The bench attempts to clear the flag while the count is still at or above the level, and checks that the flag survives. A design that cleared without comparing the count would drop the request with samples still waiting. It drains with DMA reads until the count falls below the level and expects the flag to clear on its own, and it drains with CPU reads and expects the flag to stay set. A design that mixed up these two cases would either hang a DMA channel or lose the software handshake. It also pushes into a full store, pushes and pops together at full and part-full fills, reads an empty store, and flushes with data inside. These cases expose a lost or duplicated sample, a count that drifts, a pointer that moves on an empty read, or data that leaks through a flush.

// File: rtl/rtf_pkg.sv
package rtf_pkg;

    typedef enum logic {
        FLAG_CLEAR,
        FLAG_RAISED
    } flag_st_e;

    // Fill level selected by each trigger code
    function automatic logic [7:0] trig_level(input logic [1:0] code);
        case (code)
            2'b00:   return 8'd1;
            2'b01:   return 8'd2;
            2'b10:   return 8'd4;
            default: return 8'd6;
        endcase
    endfunction

endpackage

// File: rtl/rtf_store.sv
module rtf_store #(
    parameter int              DW        = 24,
    parameter int              DEPTH     = 8,
    parameter logic [DW-1:0]   EMPTY_VAL = '0,
    localparam int             AW        = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int             CW        = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] rd_data,
    output logic [CW-1:0] cnt_q,
    output logic [CW-1:0] cnt_nxt,
    output logic          push_drop,
    output logic          pop_ok
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr_q, rd_ptr_q;
    logic [AW-1:0] wr_ptr_inc, rd_ptr_inc;
    logic          empty, full, push_ok;

    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == CW'(DEPTH));

    assign pop_ok    = pop && !empty && !flush;
    assign push_ok   = push && !flush && (!full || pop_ok);
    assign push_drop = push && !flush && full && !pop_ok;

    assign cnt_nxt = flush ? '0 : (cnt_q + CW'(push_ok) - CW'(pop_ok));

    generate
        if ((1 << AW) == DEPTH) begin : g_pow2
            assign wr_ptr_inc = wr_ptr_q + 1'b1;
            assign rd_ptr_inc = rd_ptr_q + 1'b1;
        end else begin : g_wrap
            assign wr_ptr_inc = (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
            assign rd_ptr_inc = (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else if (flush) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (push_ok) wr_ptr_q <= wr_ptr_inc;
            if (pop_ok)  rd_ptr_q <= rd_ptr_inc;
            cnt_q <= cnt_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr_q] <= push_data;
    end

    // An empty store shows a fixed value instead of stale contents
    assign rd_data = empty ? EMPTY_VAL : mem[rd_ptr_q];

endmodule

// File: rtl/rtf_regs.sv
module rtf_regs (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_we,
    input  logic [1:0] ctl_trig_code,
    input  logic       ctl_flush,
    input  logic       sts_we,
    input  logic       sts_ovf_wr,
    input  logic       push_drop,
    output logic [1:0] trig_q,
    output logic       flush_q,
    output logic       ovf_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_q  <= 2'b00;
            flush_q <= 1'b0;
        end else if (ctl_we) begin
            trig_q  <= ctl_trig_code;
            flush_q <= ctl_flush;
        end
    end

    // A new loss wins over a clear requested in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
        end else if (push_drop) begin
            ovf_q <= 1'b1;
        end else if (sts_we && !sts_ovf_wr) begin
            ovf_q <= 1'b0;
        end
    end

endmodule

// File: rtl/rtf_flag_fsm.sv
module rtf_flag_fsm #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    trig_code,
    input  logic [CW-1:0] cnt_nxt,
    input  logic          sw_clear,
    input  logic          dma_pop,
    output logic          full_flag,
    output logic          rxi_req
);
    import rtf_pkg::*;

    flag_st_e      state_q, state_d;
    logic [CW-1:0] level;
    logic          at_level;

    assign level    = CW'(trig_level(trig_code));
    assign at_level = (cnt_nxt >= level);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_CLEAR: begin
                if (at_level) state_d = FLAG_RAISED;            // RAISE
            end
            FLAG_RAISED: begin
                if (!at_level && (sw_clear || dma_pop))
                    state_d = FLAG_CLEAR;                       // SW_CLEAR / DMA_DRAIN
            end
            default: state_d = FLAG_CLEAR;
        endcase
    end

    always_comb begin
        full_flag = (state_q == FLAG_RAISED);
        rxi_req   = (state_q == FLAG_RAISED);
    end

endmodule

// File: rtl/rx_trig_fifo.sv
module rx_trig_fifo #(
    parameter int            DW        = 24,
    parameter int            DEPTH     = 8,
    parameter logic [DW-1:0] EMPTY_VAL = '0,
    localparam int           CW        = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          des_valid,
    input  logic [DW-1:0] des_data,
    input  logic          rd_strobe,
    input  logic          rd_by_dma,
    output logic [DW-1:0] rd_data,
    input  logic          ctl_we,
    input  logic [1:0]    ctl_trig_code,
    input  logic          ctl_flush,
    input  logic          sts_we,
    input  logic          sts_full_wr,
    input  logic          sts_ovf_wr,
    output logic [1:0]    trig_code_q,
    output logic          flush_q,
    output logic          full_flag,
    output logic          ovf_flag,
    output logic [CW-1:0] fill_cnt,
    output logic          rxi_req
);

    logic [CW-1:0] cnt_nxt;
    logic          push_drop, pop_ok;
    logic          dma_pop, sw_clear;

    assign dma_pop  = pop_ok && rd_by_dma;
    assign sw_clear = sts_we && !sts_full_wr;

    rtf_store #(
        .DW        (DW),
        .DEPTH     (DEPTH),
        .EMPTY_VAL (EMPTY_VAL)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush_q),
        .push      (des_valid),
        .push_data (des_data),
        .pop       (rd_strobe),
        .rd_data   (rd_data),
        .cnt_q     (fill_cnt),
        .cnt_nxt   (cnt_nxt),
        .push_drop (push_drop),
        .pop_ok    (pop_ok)
    );

    rtf_regs u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .ctl_we        (ctl_we),
        .ctl_trig_code (ctl_trig_code),
        .ctl_flush     (ctl_flush),
        .sts_we        (sts_we),
        .sts_ovf_wr    (sts_ovf_wr),
        .push_drop     (push_drop),
        .trig_q        (trig_code_q),
        .flush_q       (flush_q),
        .ovf_q         (ovf_flag)
    );

    rtf_flag_fsm #(
        .CW (CW)
    ) u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_code (trig_code_q),
        .cnt_nxt   (cnt_nxt),
        .sw_clear  (sw_clear),
        .dma_pop   (dma_pop),
        .full_flag (full_flag),
        .rxi_req   (rxi_req)
    );

endmodule

// File: rtl/rx_trig_fifo_chk.sv
module rx_trig_fifo_chk #(
    parameter int  DEPTH = 8,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          des_valid,
    input logic          rd_strobe,
    input logic          rd_by_dma,
    input logic          sts_we,
    input logic          sts_full_wr,
    input logic          sts_ovf_wr,
    input logic [1:0]    trig_code_q,
    input logic          flush_q,
    input logic          full_flag,
    input logic          ovf_flag,
    input logic [CW-1:0] fill_cnt
);
    import rtf_pkg::*;

    logic [CW-1:0] level;
    assign level = CW'(trig_level(trig_code_q));

    // R2
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_cnt <= CW'(DEPTH));

    // R3
    flag_at_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_cnt >= level) && $stable(trig_code_q) |-> full_flag);

    // R4
    write_one_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full_flag && sts_we && sts_full_wr && !(rd_strobe && rd_by_dma) |=> full_flag);

    // R4
    clear_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full_flag && sts_we && !sts_full_wr && !rd_strobe && !flush_q && (fill_cnt >= level)
        |=> full_flag);

    // R6
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_q |=> (fill_cnt == '0));

    // R8
    overflow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        des_valid && !rd_strobe && !flush_q && (fill_cnt == CW'(DEPTH))
        |=> ovf_flag && (fill_cnt == CW'(DEPTH)));

    // R8
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag && !(sts_we && !sts_ovf_wr) |=> ovf_flag);

    // R9
    push_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        des_valid && rd_strobe && !flush_q && (fill_cnt != '0)
        |=> fill_cnt == $past(fill_cnt));

endmodule

bind rx_trig_fifo rx_trig_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .des_valid   (des_valid),
    .rd_strobe   (rd_strobe),
    .rd_by_dma   (rd_by_dma),
    .sts_we      (sts_we),
    .sts_full_wr (sts_full_wr),
    .sts_ovf_wr  (sts_ovf_wr),
    .trig_code_q (trig_code_q),
    .flush_q     (flush_q),
    .full_flag   (full_flag),
    .ovf_flag    (ovf_flag),
    .fill_cnt    (fill_cnt)
);

// File: tb/rx_trig_fifo_tb.sv
`timescale 1ns/1ps
module rx_trig_fifo_tb;

    localparam int DW    = 24;
    localparam int DEPTH = 8;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          des_valid = 1'b0;
    logic [DW-1:0] des_data = '0;
    logic          rd_strobe = 1'b0;
    logic          rd_by_dma = 1'b0;
    logic [DW-1:0] rd_data;
    logic          ctl_we = 1'b0;
    logic [1:0]    ctl_trig_code = 2'b00;
    logic          ctl_flush = 1'b0;
    logic          sts_we = 1'b0;
    logic          sts_full_wr = 1'b1;
    logic          sts_ovf_wr = 1'b1;
    logic [1:0]    trig_code_q;
    logic          flush_q, full_flag, ovf_flag, rxi_req;
    logic [CW-1:0] fill_cnt;

    always #4 clk = ~clk;

    rx_trig_fifo #(.DW(DW), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .des_valid(des_valid), .des_data(des_data),
        .rd_strobe(rd_strobe), .rd_by_dma(rd_by_dma), .rd_data(rd_data),
        .ctl_we(ctl_we), .ctl_trig_code(ctl_trig_code), .ctl_flush(ctl_flush),
        .sts_we(sts_we), .sts_full_wr(sts_full_wr), .sts_ovf_wr(sts_ovf_wr),
        .trig_code_q(trig_code_q), .flush_q(flush_q), .full_flag(full_flag),
        .ovf_flag(ovf_flag), .fill_cnt(fill_cnt), .rxi_req(rxi_req)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int lvl(input logic [1:0] code);
        case (code)
            2'b00:   return 1;
            2'b01:   return 2;
            2'b10:   return 4;
            default: return 6;
        endcase
    endfunction

    // Scoreboard model state
    logic [DW-1:0] exp_q[$];
    logic [1:0]    trig_mdl  = 2'b00;
    logic          flush_mdl = 1'b0;
    logic          flag_mdl  = 1'b0;
    logic          ovf_mdl   = 1'b0;
    logic          pop_e, push_e, drop_e;

    // Monitor: compares outputs with the model, then advances the model by this cycle's inputs
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2 fill_cnt", 32'(fill_cnt), 32'(exp_q.size()));
            check("R3 full_flag", 32'(full_flag), 32'(flag_mdl));
            check("R3 rxi_req", 32'(rxi_req), 32'(flag_mdl));
            check("R8 ovf_flag", 32'(ovf_flag), 32'(ovf_mdl));
            if (rd_strobe && !flush_mdl) begin
                if (exp_q.size() != 0) check("R2 read order", 32'(rd_data), 32'(exp_q[0]));
                else                   check("R7 empty read", 32'(rd_data), 32'h0);
            end
            pop_e  = rd_strobe && !flush_mdl && (exp_q.size() != 0);
            push_e = des_valid && !flush_mdl && ((exp_q.size() < DEPTH) || pop_e);
            drop_e = des_valid && !flush_mdl && (exp_q.size() == DEPTH) && !pop_e;
            if (flush_mdl) exp_q.delete();
            else begin
                if (pop_e)  void'(exp_q.pop_front());
                if (push_e) exp_q.push_back(des_data);
            end
            if (exp_q.size() >= lvl(trig_mdl)) flag_mdl = 1'b1;
            else if (flag_mdl && ((sts_we && !sts_full_wr) || (pop_e && rd_by_dma))) flag_mdl = 1'b0;
            if (drop_e) ovf_mdl = 1'b1;
            else if (sts_we && !sts_ovf_wr) ovf_mdl = 1'b0;
            if (ctl_we) begin
                trig_mdl  = ctl_trig_code;
                flush_mdl = ctl_flush;
            end
        end
    end

    // Driver tasks: each holds its inputs for one clock cycle
    task automatic push(input logic [DW-1:0] d);
        @(posedge clk); #1; des_valid = 1'b1; des_data = d;
        @(posedge clk); #1; des_valid = 1'b0;
    endtask

    task automatic rd(input logic dma);
        @(posedge clk); #1; rd_strobe = 1'b1; rd_by_dma = dma;
        @(posedge clk); #1; rd_strobe = 1'b0; rd_by_dma = 1'b0;
    endtask

    task automatic push_pop(input logic [DW-1:0] d);
        @(posedge clk); #1; des_valid = 1'b1; des_data = d; rd_strobe = 1'b1;
        @(posedge clk); #1; des_valid = 1'b0; rd_strobe = 1'b0;
    endtask

    task automatic ctl(input logic [1:0] code, input logic fl);
        @(posedge clk); #1; ctl_we = 1'b1; ctl_trig_code = code; ctl_flush = fl;
        @(posedge clk); #1; ctl_we = 1'b0;
    endtask

    task automatic sts(input logic fw, input logic ow);
        @(posedge clk); #1; sts_we = 1'b1; sts_full_wr = fw; sts_ovf_wr = ow;
        @(posedge clk); #1; sts_we = 1'b0; sts_full_wr = 1'b1; sts_ovf_wr = 1'b1;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    endtask

    initial begin
        #(8ns * 100000);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        check("R1 fill_cnt", 32'(fill_cnt), 32'd0);
        check("R1 full_flag", 32'(full_flag), 32'd0);
        check("R1 ovf_flag", 32'(ovf_flag), 32'd0);
        check("R1 rxi_req", 32'(rxi_req), 32'd0);
        check("R1 flush_q", 32'(flush_q), 32'd0);
        check("R1 trig_code_q", 32'(trig_code_q), 32'd0);
        check("R1 rd_data", 32'(rd_data), 32'd0);

        // R3/R4 with level 1
        ctl(2'b00, 1'b0);
        push(24'h000111);
        check("R3 level1 flag", 32'(full_flag), 32'd1);
        sts(1'b1, 1'b1);
        check("R4 write one ignored", 32'(full_flag), 32'd1);
        sts(1'b0, 1'b1);
        check("R4 clear refused at level", 32'(full_flag), 32'd1);
        rd(1'b0);
        check("R4 sticky after cpu drain", 32'(full_flag), 32'd1);
        sts(1'b0, 1'b1);
        check("R4 clear below level", 32'(full_flag), 32'd0);

        // R3 level 2
        ctl(2'b01, 1'b0);
        check("R3 trig code stored", 32'(trig_code_q), 32'd1);
        push(24'h000201);
        check("R3 level2 below", 32'(full_flag), 32'd0);
        push(24'h000202);
        check("R3 level2 reached", 32'(rxi_req), 32'd1);
        rd(1'b0); rd(1'b0);
        sts(1'b0, 1'b1);
        check("R4 clear after drain", 32'(full_flag), 32'd0);

        // R5 level 4 with DMA drain
        ctl(2'b10, 1'b0);
        for (int i = 0; i < 3; i++) push(24'h000400 + 24'(i));
        check("R3 level4 below", 32'(full_flag), 32'd0);
        push(24'h000403);
        check("R3 level4 reached", 32'(full_flag), 32'd1);
        rd(1'b1);
        check("R5 dma drain clears", 32'(full_flag), 32'd0);
        check("R5 count after dma read", 32'(fill_cnt), 32'd3);
        for (int i = 0; i < 3; i++) rd(1'b1);

        // R8/R9 level 6, overflow, push+pop at full
        ctl(2'b11, 1'b0);
        for (int i = 0; i < 5; i++) push(24'h000600 + 24'(i));
        check("R3 level6 below", 32'(full_flag), 32'd0);
        push(24'h000605);
        check("R3 level6 reached", 32'(full_flag), 32'd1);
        push(24'h000606); push(24'h000607);
        check("R2 full count", 32'(fill_cnt), 32'd8);
        push(24'h0006FF);
        check("R8 dropped count", 32'(fill_cnt), 32'd8);
        check("R8 overflow set", 32'(ovf_flag), 32'd1);
        sts(1'b1, 1'b1);
        check("R8 overflow write one", 32'(ovf_flag), 32'd1);
        push_pop(24'h000608);
        check("R9 full push+pop count", 32'(fill_cnt), 32'd8);
        sts(1'b1, 1'b0);
        check("R8 overflow cleared", 32'(ovf_flag), 32'd0);
        check("R4 flag kept on write one", 32'(full_flag), 32'd1);
        for (int i = 0; i < 8; i++) rd(1'b0);
        sts(1'b0, 1'b1);

        // R9 part-full push+pop
        for (int i = 0; i < 3; i++) push(24'h000900 + 24'(i));
        push_pop(24'h000903);
        check("R9 partial push+pop count", 32'(fill_cnt), 32'd3);
        for (int i = 0; i < 3; i++) rd(1'b0);

        // R7 empty read
        check("R7 empty value", 32'(rd_data), 32'd0);
        rd(1'b0);
        check("R7 count after empty read", 32'(fill_cnt), 32'd0);
        push(24'h000ABC);
        check("R7 next read after empty", 32'(rd_data), 32'h000ABC);
        rd(1'b0);

        // R6 flush
        ctl(2'b00, 1'b0);
        for (int i = 0; i < 5; i++) push(24'h000C00 + 24'(i));
        check("R6 pre-flush flag", 32'(full_flag), 32'd1);
        ctl(2'b00, 1'b1);
        @(posedge clk); #1;
        check("R6 flushed count", 32'(fill_cnt), 32'd0);
        push(24'h000055);
        check("R6 push discarded", 32'(fill_cnt), 32'd0);
        sts(1'b0, 1'b1);
        check("R6 clear after flush", 32'(full_flag), 32'd0);
        ctl(2'b00, 1'b0);
        push(24'h000066);
        check("R6 count after release", 32'(fill_cnt), 32'd1);
        check("R6 data after release", 32'(rd_data), 32'h000066);
        rd(1'b0);
        sts(1'b0, 1'b1);

        repeat (2) @(posedge clk);
        #1;
        done = 1'b1;
        summary();
        $finish;
    end

endmodule